// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits inside the access logic of a synchronous DRAM controller. When a read or write is issued, it receives the first column and then produces one column address per clock for the rest of the burst. The burst length and the ordering come from a mode word, which is captured whenever a burst is launched.

Two orderings are supported. Sequential ordering counts upward inside an aligned block. Interleaved ordering XORs the start column with the beat number. A full-page length counts through every column of the row, wraps, and keeps going until the burst is stopped or restarted.

A separate restart strobe can present a new column on any cycle. The burst then begins again at that column with the mode already held, so random column accesses can be issued on every clock.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held, and after it is released, `valid_o` and `done_o` are 0 and `col_o` is 0. Whenever `valid_o` is 0, `col_o` is 0.
- R2: `start_i` captures `mode_i` and launches a burst. On the next cycle `valid_o` is 1 and `col_o` equals `start_col_i`. In the mode word, bits [2:0] select the length (000=1, 001=2, 010=4, 011=8, 111=full page) and bit 3 selects the type (0 sequential, 1 interleaved).
- R3: Beats advance once per clock. A burst of finite length N keeps `valid_o` high for exactly N cycles. `done_o` is 1 only on the last of those cycles, and `valid_o` falls on the cycle after it.
- R4: For a sequential burst of length N (2, 4 or 8), beat k outputs the start column with its low log2(N) bits replaced by (start + k) mod N. The upper bits stay fixed.
- R5: For an interleaved burst of length N (2, 4 or 8), beat k outputs the start column with its low log2(N) bits XORed with k.
- R6: A full-page burst outputs (start + k) mod 2^COL_W and never raises `done_o`. It keeps running past the wrap. The type bit has no effect at this length.
- R7: `newcol_i` on any cycle restarts the burst at `start_col_i` from beat 0, using the mode captured by the last `start_i`. The value on `mode_i` is ignored at that time. Before any `start_i`, the held mode is length 1, sequential.
- R8: When `start_i` and `newcol_i` are high together, the restart uses the new `mode_i`, exactly as for `start_i` alone.
- R9: `stop_i` ends a running burst, so `valid_o` is 0 on the next cycle. A start or restart strobe in the same cycle takes priority over `stop_i`.
- R10: The unassigned length codes 100, 101 and 110 behave as length 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Launch a burst and capture the mode word |
| newcol_i | input | 1 | Restart at a new column, keeping the held mode |
| stop_i | input | 1 | Terminate the running burst |
| start_col_i | input | COL_W | Column used by start_i or newcol_i |
| mode_i | input | 4 | Mode word: [2:0] length code, [3] ordering type |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | A burst beat is being presented |
| done_o | output | 1 | Last beat of a finite burst |

## Verification
The bench builds the block with COL_W = 8, which gives 256 columns. At that size a full-page burst crosses its wrap from column 255 to column 0 within a few hundred cycles, so R6 is observed past the wrap and not only in its first beats. With eight-bit columns, the upper column bits sit above an eight-beat window. Aligned-block wrapping and the fixed upper bits are therefore checked for every finite length, from start columns near both ends of the range.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam int MODE_W   = 4;
  localparam int TYPE_BIT = 3;

  typedef enum logic [2:0] {
    BL_ONE  = 3'b000,
    BL_TWO  = 3'b001,
    BL_FOUR = 3'b010,
    BL_OCT  = 3'b011,
    BL_PAGE = 3'b111
  } burst_len_e;

  // number of low column bits that take part in a finite burst
  function automatic logic [1:0] span_bits(input logic [2:0] code);
    logic [1:0] n;
    case (code)
      BL_TWO:  n = 2'd1;
      BL_FOUR: n = 2'd2;
      BL_OCT:  n = 2'd3;
      default: n = 2'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg #(
  parameter int COL_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cap_en,
  input  logic [burst_col_pkg::MODE_W-1:0]    mode_i,
  output logic [COL_W-1:0]                    mask_o,
  output logic                                full_o,
  output logic                                ilv_o
);
  import burst_col_pkg::*;

  logic [1:0] nbits_d, nbits_q;
  logic       full_d, full_q;
  logic       ilv_d, ilv_q;

  always_comb begin
    nbits_d = span_bits(mode_i[2:0]);
    full_d  = (mode_i[2:0] == BL_PAGE);
    ilv_d   = mode_i[TYPE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbits_q <= 2'd0;
      full_q  <= 1'b0;
      ilv_q   <= 1'b0;
    end else if (cap_en) begin
      nbits_q <= nbits_d;
      full_q  <= full_d;
      ilv_q   <= ilv_d;
    end
  end

  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask_o[i] = full_q | (i < int'(nbits_q));
  end

  assign full_o = full_q;
  assign ilv_o  = ilv_q;

endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  output logic             active_o,
  output logic             last_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] beat_o
);

  logic             act_d, act_q;
  logic [COL_W-1:0] base_d, base_q;
  logic [COL_W-1:0] beat_d, beat_q;
  logic             last;

  assign last = act_q & ~full_i & (beat_q == mask_i);

  always_comb begin
    act_d  = act_q;
    base_d = base_q;
    beat_d = beat_q;
    if (load_i) begin
      act_d  = 1'b1;
      base_d = col_i;
      beat_d = '0;
    end else if (stop_i) begin
      act_d  = 1'b0;
    end else if (act_q) begin
      if (last) act_d = 1'b0;
      else      beat_d = beat_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
    end else begin
      act_q  <= act_d;
      base_q <= base_d;
      beat_q <= beat_d;
    end
  end

  assign active_o = act_q;
  assign last_o   = last;
  assign base_o   = base_q;
  assign beat_o   = beat_q;

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  input  logic             full_i,
  output logic [COL_W-1:0] col_o
);

  logic             use_xor;
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] flip;
  logic [COL_W-1:0] low;

  assign use_xor = ilv_i & ~full_i;
  assign sum     = base_i + beat_i;
  assign flip    = base_i ^ beat_i;
  assign low     = use_xor ? flip : sum;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col_o[i] = mask_i[i] ? low[i] : base_i[i];
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start_i,
  input  logic                             newcol_i,
  input  logic                             stop_i,
  input  logic [COL_W-1:0]                 start_col_i,
  input  logic [burst_col_pkg::MODE_W-1:0] mode_i,
  output logic [COL_W-1:0]                 col_o,
  output logic                             valid_o,
  output logic                             done_o
);

  logic [1:0]       rst_pipe;
  logic             rst_n_sync;
  logic [COL_W-1:0] mask;
  logic             full, ilv;
  logic             active, last;
  logic [COL_W-1:0] base, beat, mapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  burst_mode_reg #(.COL_W(COL_W)) mode_i_reg (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .cap_en (start_i),
    .mode_i (mode_i),
    .mask_o (mask),
    .full_o (full),
    .ilv_o  (ilv)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) beat_i (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load_i   (start_i | newcol_i),
    .stop_i   (stop_i),
    .col_i    (start_col_i),
    .mask_i   (mask),
    .full_i   (full),
    .active_o (active),
    .last_o   (last),
    .base_o   (base),
    .beat_o   (beat)
  );

  burst_addr_map #(.COL_W(COL_W)) map_i (
    .base_i (base),
    .beat_i (beat),
    .mask_i (mask),
    .ilv_i  (ilv),
    .full_i (full),
    .col_o  (mapped)
  );

  assign valid_o = active;
  assign done_o  = last;
  assign col_o   = active ? mapped : '0;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             newcol_i,
  input logic             stop_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [3:0]       mode_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             done_o
);

  logic [2:0]       len_q;
  logic [COL_W-1:0] win_mask;
  logic             pg;
  logic             quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       len_q <= 3'b000;
    else if (start_i) len_q <= mode_i[2:0];
  end

  always_comb begin
    pg = (len_q == 3'b111);
    case (len_q)
      3'b001:  win_mask = COL_W'(1);
      3'b010:  win_mask = COL_W'(3);
      3'b011:  win_mask = COL_W'(7);
      3'b111:  win_mask = '1;
      default: win_mask = '0;
    endcase
  end

  assign quiet = !start_i && !newcol_i && !stop_i;

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (col_o == '0 && !done_o));

  p_launch_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i || newcol_i) |=> (valid_o && col_o == $past(start_col_i)));

  p_done_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && quiet) |=> !valid_o);

  p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !done_o && quiet && !pg) |=>
      ((col_o & ~win_mask) == ($past(col_o) & ~win_mask)));

  p_page_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && quiet && pg) |=> (valid_o && col_o == COL_W'($past(col_o) + 1'b1)));

  p_page_nodone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && pg) |-> !done_o);

  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i && !newcol_i) |=> !valid_o);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .start_i     (start_i),
  .newcol_i    (newcol_i),
  .stop_i      (stop_i),
  .start_col_i (start_col_i),
  .mode_i      (mode_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .done_o      (done_o)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int COL_W      = 8;

  logic             clk;
  logic             rst_n;
  logic             start_i, newcol_i, stop_i;
  logic [COL_W-1:0] start_col_i;
  logic [3:0]       mode_i;
  logic [COL_W-1:0] col_o;
  logic             valid_o, done_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // reference state
  bit               m_act;
  logic [COL_W-1:0] m_base;
  int               m_beat;
  logic [3:0]       m_mode;
  string            m_tag;

  burst_col_gen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .newcol_i(newcol_i),
    .stop_i(stop_i), .start_col_i(start_col_i), .mode_i(mode_i),
    .col_o(col_o), .valid_o(valid_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int burst_len(input logic [3:0] md);
    case (md[2:0])
      3'b001:  return 2;
      3'b010:  return 4;
      3'b011:  return 8;
      3'b111:  return 1 << COL_W;
      default: return 1;
    endcase
  endfunction

  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] b,
                                               input int k, input logic [3:0] md);
    int n = burst_len(md);
    logic [COL_W-1:0] msk, kk, lo;
    kk = COL_W'(k);
    if (md[2:0] == 3'b111) return b + kk;
    msk = COL_W'(n - 1);
    lo  = md[3] ? ((b ^ kk) & msk) : ((b + kk) & msk);
    return (b & ~msk) | lo;
  endfunction

  function automatic bit exp_last();
    return m_act && (m_mode[2:0] != 3'b111) && (m_beat == burst_len(m_mode) - 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    logic [COL_W-1:0] ec;
    string ct;
    ec = m_act ? exp_col(m_base, m_beat, m_mode) : '0;
    if (m_mode[2:0] == 3'b111)                   ct = "R6";
    else if (burst_len(m_mode) == 1 && m_mode[2]) ct = "R10";
    else if (m_mode[3])                          ct = "R5";
    else                                         ct = "R4";
    check({m_tag, " R3 valid"}, 32'(valid_o), 32'(m_act));
    check({m_tag, " R3 done"},  32'(done_o),  32'(exp_last()));
    check({m_tag, " ", ct, " col"}, 32'(col_o), 32'(ec));
  endtask

  // drive one cycle of inputs, advance the model, then compare at the next negedge
  task automatic step(input bit st, input bit nc, input bit sp,
                      input logic [COL_W-1:0] c, input logic [3:0] md);
    bit lst;
    start_i = st; newcol_i = nc; stop_i = sp; start_col_i = c; mode_i = md;
    lst = exp_last();
    if (st || nc) begin
      m_act = 1; m_base = c; m_beat = 0;
      if (st) m_mode = md;
      m_tag = st ? (nc ? "R8" : "R2") : "R7";
    end else if (sp) begin
      m_act = 0; m_tag = "R9";
    end else if (m_act) begin
      if (lst) m_act = 0; else m_beat = (m_beat + 1) % (1 << COL_W);
      m_tag = "run";
    end else m_tag = "idle";
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, COL_W'($urandom), 4'($urandom));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    start_i = 0; newcol_i = 0; stop_i = 0; start_col_i = '0; mode_i = '0;
    m_act = 0; m_base = '0; m_beat = 0; m_mode = '0; m_tag = "R1";
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 32'(valid_o), 0);
    check("R1 col in reset", 32'(col_o), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 valid after reset", 32'(valid_o), 0);
    check("R1 done after reset", 32'(done_o), 0);

    // R4 sequential length 4 near the block edge: 3E 3F 3C 3D
    step(1, 0, 0, 8'h3E, 4'b0010); idle(5);
    // R5 interleaved length 8: 35 34 37 36 31 30 33 32
    step(1, 0, 0, 8'h35, 4'b1011); idle(9);
    // R4 sequential length 2 at top column
    step(1, 0, 0, 8'hFF, 4'b0001); idle(3);
    // length 1 and R10 reserved codes
    step(1, 0, 0, 8'h12, 4'b0000); idle(2);
    step(1, 0, 0, 8'h77, 4'b0101); idle(2);
    step(1, 0, 0, 8'h78, 4'b1110); idle(2);
    // R6 full page, type bit set, crosses the wrap, then R9 stop
    step(1, 0, 0, 8'hFA, 4'b1111); idle(300);
    step(0, 0, 1, 8'h00, 4'b0000); idle(2);
    // R7 restart mid burst, mode_i differs and is ignored
    step(1, 0, 0, 8'h40, 4'b1011); idle(2);
    step(0, 1, 0, 8'h9C, 4'b0001); idle(9);
    // R8 start and restart together pick up the new mode
    step(1, 0, 0, 8'h20, 4'b0011); idle(1);
    step(1, 1, 0, 8'h5D, 4'b1010); idle(5);
    // R9 stop loses to a same-cycle restart
    step(1, 0, 0, 8'h10, 4'b0111); idle(3);
    step(0, 1, 1, 8'hC3, 4'b0000); idle(3);
    step(0, 0, 1, 8'h00, 4'b0000); idle(1);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] md;
      int sel = $urandom_range(0, 7);
      md = {1'($urandom), (sel == 7) ? 3'b111 : (sel >= 5) ? 3'($urandom_range(4, 6))
                                                            : 3'(sel & 3)};
      step($urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
           $urandom_range(0, 63) == 0, COL_W'($urandom), md);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R3 actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule